// File: doc/BRIEF.md
# Reservation Unit for Atomic Word Stores

This unit pairs a load-and-reserve word instruction with a later conditional store word instruction. One 32-bit instruction word can arrive per cycle, together with the values of its base, index and source registers. The unit decodes the word and forms the effective address as base plus index. For a load-and-reserve it records a reservation on the addressed word. For a conditional store it decides whether the store may commit. One cycle later it issues the memory write and reports a 4-bit condition code. On a failed attempt it reports the condition code and issues no write.

The unit holds one reservation, made of a valid flag and a word address. A snoop port sees stores from other agents, and such a store to the reserved word ends the reservation. Every conditional store also ends it, whether the store succeeds or fails. The load data path, the register file and all other instructions belong to other blocks.

Top module: `resv_store_unit`

## Requirements
- R1: After reset there is no reservation, and `wr_valid` and `cc_valid` are low.
- R2: The unit accepts a conditional store only when all three of these hold: `ins_word[31:26]` is 6'b011111, `ins_word[10:2]` is 168, and `ins_word[1:0]` is 2'b01. Any other word presented with `ins_valid` produces no output and leaves the reservation unchanged.
- R3: A load-and-reserve is recognised when `ins_word[31:26]` is 6'b011111, `ins_word[10:2]` is 10 and `ins_word[1:0]` is 2'b00. It reserves the word at its effective address.
- R4: The effective address is `base_val + index_val` modulo 2^32, and a committed write uses this full address.
- R5: A conditional store that hits the reservation does three things on the cycle after it is presented. It raises `wr_valid` with `wr_addr` set to the effective address and `wr_data` set to `src_val`. It raises `cc_valid`, and it sets `cc_code` to 4'b0000.
- R6: A conditional store with no reservation held raises `cc_valid` with `cc_code` = 4'b1000 on the next cycle, and `wr_valid` stays low.
- R7: Only address bits [31:2] take part in the reservation match. A store whose word address differs from the reserved one fails as in R6.
- R8: Every conditional store clears the reservation, whether it succeeds or fails.
- R9: A snoop store (`snp_valid`) to the reserved word clears the reservation. A snoop to another word does not.
- R10: A snoop to the reserved word in the same cycle as a conditional store to that word makes the store fail.
- R11: A new load-and-reserve replaces any earlier reservation.
- R12: A load-and-reserve in the same cycle as a snoop to its own word still establishes the reservation.
- R13: `cc_valid` and `wr_valid` are single-cycle pulses and are high only on the cycle after a conditional store is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word and operands are valid |
| ins_word | input | 32 | Instruction word; its bit 31 is bit 0 in big-endian numbering |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| src_val | input | 32 | Source register value for the store |
| snp_valid | input | 1 | Another agent stores this cycle |
| snp_addr | input | 32 | Byte address of the snooped store |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data word |
| cc_valid | output | 1 | Condition code is valid |
| cc_code | output | 4 | Condition code: 4'b0000 on success, 4'b1000 on failure |

## Verification
The bench targets the cases where a unit can easily act on a stale reservation:
- A second store after a successful one. A design that does not clear on success writes twice.
- A store after a failed, mismatched attempt. Missing the clear on failure lets a later store commit.
- A snoop in the same cycle as the store. Wrong ordering lets the store commit over the other agent's data.
- A snoop to a neighbouring word, which must not break the reservation.
- A load-and-reserve that replaces an earlier one.
- An effective address that wraps past 2^32.
- Low address bits that differ from the reserved address but must still match.

The decode tests use words that differ from a valid store only in the primary opcode, the extended opcode or the record bits. A loose decoder would write or report on these words, or would disturb the reservation.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int unsigned INS_W = 32;
  localparam logic [5:0] PRIM_OP = 6'b011111;
  localparam logic [8:0] XO_STCOND = 9'd168;
  localparam logic [8:0] XO_LDRES = 9'd10;
  localparam logic [1:0] TAIL_STCOND = 2'b01;
  localparam logic [1:0] TAIL_LDRES = 2'b00;
  localparam logic [3:0] CC_PASS = 4'b0000;
  localparam logic [3:0] CC_FAIL = 4'b1000;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LDRES  = 2'd1,
    OP_STCOND = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rsu_decode.sv
module rsu_decode
  import rsu_pkg::*;
(
  input  logic             valid,
  input  logic [INS_W-1:0] word,
  output op_kind_e         kind
);
  logic [5:0] prim;
  logic [8:0] xo;
  logic [1:0] tail;

  always_comb begin
    prim = word[31:26];
    xo   = word[10:2];
    tail = word[1:0];
    kind = OP_NONE;
    if (valid && prim == PRIM_OP) begin
      if (xo == XO_STCOND && tail == TAIL_STCOND) kind = OP_STCOND;
      else if (xo == XO_LDRES && tail == TAIL_LDRES) kind = OP_LDRES;
    end
  end
endmodule

// File: rtl/rsu_agu.sv
module rsu_agu #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic [ADDR_W-1:0] ea
);
  always_comb ea = base + index;
endmodule

// File: rtl/rsu_resv_reg.sv
module rsu_resv_reg #(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              sc_en,
  input  logic [WORD_W-1:0] ea_word,
  input  logic              snp_valid,
  input  logic [WORD_W-1:0] snp_word,
  output logic              hit,
  output logic              held
);
  logic              v_q, v_d;
  logic [WORD_W-1:0] a_q, a_d;
  logic              snp_kill;
  logic              upd_en;

  always_comb begin
    snp_kill = snp_valid && v_q && (snp_word == a_q);
    hit      = v_q && (ea_word == a_q) && !snp_kill;
    v_d      = v_q;
    a_d      = a_q;
    upd_en   = 1'b0;
    if (set_en) begin
      v_d    = 1'b1;
      a_d    = ea_word;
      upd_en = 1'b1;
    end else if (sc_en || snp_kill) begin
      v_d    = 1'b0;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
    end else if (upd_en) begin
      v_q <= v_d;
      a_q <= a_d;
    end
  end

  assign held = v_q;
endmodule

// File: rtl/resv_store_unit.sv
module resv_store_unit
  import rsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [INS_W-1:0]  ins_word,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cc_valid,
  output logic [3:0]        cc_code
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  op_kind_e          kind;
  logic [ADDR_W-1:0] ea;
  logic              hit;
  logic              held;
  logic              sc_en;

  logic              wv_q, wv_d, cv_q, cv_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [3:0]        cc_q, cc_d;

  rsu_decode u_dec (.valid(ins_valid), .word(ins_word), .kind(kind));

  rsu_agu #(.ADDR_W(ADDR_W)) u_agu (.base(base_val), .index(index_val), .ea(ea));

  assign sc_en = (kind == OP_STCOND);

  rsu_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set_en(kind == OP_LDRES), .sc_en(sc_en),
    .ea_word(ea[ADDR_W-1:2]),
    .snp_valid(snp_valid), .snp_word(snp_addr[ADDR_W-1:2]),
    .hit(hit), .held(held)
  );

  always_comb begin
    cv_d = sc_en;
    wv_d = sc_en && hit;
    wa_d = wa_q;
    wd_d = wd_q;
    cc_d = cc_q;
    if (sc_en) begin
      wa_d = ea;
      wd_d = src_val;
      cc_d = hit ? CC_PASS : CC_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      cv_q <= 1'b0;
    end else begin
      wv_q <= wv_d;
      cv_q <= cv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      wd_q <= '0;
      cc_q <= '0;
    end else if (sc_en) begin
      wa_q <= wa_d;
      wd_q <= wd_d;
      cc_q <= cc_d;
    end
  end

  assign wr_valid = wv_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
  assign cc_valid = cv_q;
  assign cc_code  = cc_q;
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_valid,
  input logic       wr_valid,
  input logic       cc_valid,
  input logic [3:0] cc_code,
  input logic       held
);
  // R5
  pass_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (cc_valid && cc_code == 4'b0000));
  // R6
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_code == 4'b1000) |-> !wr_valid);
  // R13
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> (cc_code == 4'b0000 || cc_code == 4'b1000));
  // R13
  needs_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> $past(ins_valid));
  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && $past(cc_valid)) |-> !wr_valid);
  // R8
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> !held);
endmodule

bind resv_store_unit rsu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
  .wr_valid(wr_valid), .cc_valid(cc_valid), .cc_code(cc_code), .held(held)
);

// File: tb/resv_store_unit_tb.sv
module resv_store_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid;
  logic [31:0] ins_word, base_val, index_val, src_val, snp_addr;
  logic        snp_valid;
  logic        wr_valid, cc_valid;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  cc_code;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  resv_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .base_val(base_val), .index_val(index_val), .src_val(src_val),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cc_valid(cc_valid), .cc_code(cc_code)
  );

  localparam logic [31:0] SC = {6'd31, 5'd1, 5'd3, 5'd4, 9'd168, 2'b01};
  localparam logic [31:0] LR = {6'd31, 5'd5, 5'd0, 5'd3, 9'd10, 2'b00};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive one cycle from a falling edge, outputs sampled at the next falling edge
  task automatic issue(input logic [31:0] w, input logic [31:0] b, input logic [31:0] x,
                       input logic [31:0] s, input logic sv, input logic [31:0] sa);
    ins_valid = 1'b1; ins_word = w; base_val = b; index_val = x; src_val = s;
    snp_valid = sv; snp_addr = sa;
    @(negedge clk);
    ins_valid = 1'b0; snp_valid = 1'b0;
  endtask

  task automatic snoop(input logic [31:0] sa);
    snp_valid = 1'b1; snp_addr = sa;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic expect_pass(input string req, input logic [31:0] a, input logic [31:0] d);
    chk(req, {31'd0, wr_valid}, 1);
    chk(req, wr_addr, a);
    chk(req, wr_data, d);
    chk(req, {31'd0, cc_valid}, 1);
    chk(req, {28'd0, cc_code}, 0);
  endtask

  task automatic expect_fail(input string req);
    chk(req, {31'd0, wr_valid}, 0);
    chk(req, {31'd0, cc_valid}, 1);
    chk(req, {28'd0, cc_code}, 32'h8);
  endtask

  task automatic expect_quiet(input string req);
    chk(req, {31'd0, wr_valid}, 0);
    chk(req, {31'd0, cc_valid}, 0);
  endtask

  task automatic t_reset;
    expect_quiet("R1 reset outputs");
    issue(SC, 32'h0, 32'h0, 32'h1234, 1'b0, 0);
    expect_fail("R1 R6 no reservation after reset");
  endtask

  task automatic t_success;
    issue(LR, 32'h100, 32'h20, 0, 1'b0, 0);
    expect_quiet("R13 quiet after load-reserve");
    issue(SC, 32'h110, 32'h10, 32'hDEADBEEF, 1'b0, 0);
    expect_pass("R5 R3 success", 32'h120, 32'hDEADBEEF);
    @(negedge clk);
    expect_quiet("R13 single pulse");
  endtask

  task automatic t_clear;
    issue(LR, 32'h180, 0, 0, 1'b0, 0);
    issue(SC, 32'h180, 0, 32'h11, 1'b0, 0);
    expect_pass("R8 first store", 32'h180, 32'h11);
    issue(SC, 32'h180, 0, 32'h22, 1'b0, 0);
    expect_fail("R8 cleared by success");
    issue(LR, 32'h1C0, 0, 0, 1'b0, 0);
    issue(SC, 32'h1D0, 0, 32'h33, 1'b0, 0);
    expect_fail("R7 mismatched word");
    issue(SC, 32'h1C0, 0, 32'h44, 1'b0, 0);
    expect_fail("R8 cleared by failure");
  endtask

  task automatic t_addr;
    issue(LR, 32'h200, 0, 0, 1'b0, 0);
    issue(SC, 32'h203, 0, 32'h55, 1'b0, 0);
    expect_pass("R7 R4 low bits ignored", 32'h203, 32'h55);
    issue(LR, 32'h8, 32'h8, 0, 1'b0, 0);
    issue(SC, 32'hFFFF_FFF0, 32'h20, 32'h66, 1'b0, 0);
    expect_pass("R4 wraparound", 32'h10, 32'h66);
  endtask

  task automatic t_snoop;
    issue(LR, 32'h300, 0, 0, 1'b0, 0);
    snoop(32'h304);
    issue(SC, 32'h300, 0, 32'h77, 1'b0, 0);
    expect_pass("R9 neighbour snoop keeps", 32'h300, 32'h77);
    issue(LR, 32'h300, 0, 0, 1'b0, 0);
    snoop(32'h302);
    issue(SC, 32'h300, 0, 32'h88, 1'b0, 0);
    expect_fail("R9 snoop clears");
    issue(LR, 32'h400, 0, 0, 1'b0, 0);
    issue(SC, 32'h400, 0, 32'h99, 1'b1, 32'h401);
    expect_fail("R10 same-cycle snoop");
  endtask

  task automatic t_replace;
    issue(LR, 32'h500, 0, 0, 1'b0, 0);
    issue(LR, 32'h600, 0, 0, 1'b0, 0);
    issue(SC, 32'h500, 0, 32'hAA, 1'b0, 0);
    expect_fail("R11 old reservation gone");
    issue(LR, 32'h500, 0, 0, 1'b0, 0);
    issue(LR, 32'h600, 0, 0, 1'b0, 0);
    issue(SC, 32'h600, 0, 32'hBB, 1'b0, 0);
    expect_pass("R11 new reservation", 32'h600, 32'hBB);
    issue(LR, 32'h700, 0, 0, 1'b1, 32'h700);
    issue(SC, 32'h700, 0, 32'hCC, 1'b0, 0);
    expect_pass("R12 reserve beats snoop", 32'h700, 32'hCC);
  endtask

  task automatic t_decode;
    issue(LR, 32'h800, 0, 0, 1'b0, 0);
    issue({6'd31, 15'd0, 9'd150, 2'b01}, 32'h800, 0, 32'h1, 1'b0, 0);
    expect_quiet("R2 wrong extended opcode");
    issue({6'd30, 15'd0, 9'd168, 2'b01}, 32'h800, 0, 32'h2, 1'b0, 0);
    expect_quiet("R2 wrong primary opcode");
    issue({6'd31, 15'd0, 9'd168, 2'b00}, 32'h800, 0, 32'h3, 1'b0, 0);
    expect_quiet("R2 wrong record bits");
    issue({6'd31, 15'd0, 9'd10, 2'b01}, 32'h900, 0, 0, 1'b0, 0);
    expect_quiet("R3 bad reserve form");
    issue(SC, 32'h800, 0, 32'hEE, 1'b0, 0);
    expect_pass("R2 R3 reservation untouched", 32'h800, 32'hEE);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_word = '0; base_val = '0; index_val = '0;
    src_val = '0; snp_valid = 1'b0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_success;
    t_clear;
    t_addr;
    t_snoop;
    t_replace;
    t_decode;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule